// File: doc/BRIEF.md
# Cyclic Receive Pool Read Window

This block sits between the receive side of one serial frame channel and the host. Received bytes come in on a write port, and an end marker on the last byte closes the block. A block also closes by itself when it reaches the size of the pool, which is 32 bytes by default. Storage is split into banks of one pool each. The writer fills one bank while the host reads another, so bytes already stored for a later block never share locations with the block the host is reading.

The host reads through an address window as wide as the pool. Every address in the window returns the byte at the current read position, and that position then moves on by one. A count output gives the number of valid bytes in the pending block. A ready flag says whether a block is pending at all. Reads past the count are not blocked: they return whatever the bank held from earlier use. Past the end of the pool the position wraps around to the start of the bank. When the host has finished with a block, a release pulse frees the bank, moves the host to the next bank and resets the read position to that bank's first byte.

Top module: `rxw_window`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `blk_cnt` is 0, `blk_rdy` is 0 and `rd_data` is 0.
- R2: The value on `rd_addr` has no effect. Each accepted read returns the byte at the current read position, whatever window address is presented.
- R3: After the clock edge that stores a byte with `wr_last` high, `blk_rdy` is 1 and `blk_cnt` holds the number of bytes in that block. A full 32-byte block shows `blk_cnt` = 0 with `blk_rdy` = 1. Until a release, both values stay unchanged.
- R4: When a block reaches 32 bytes without an end marker, it closes on the edge that stores the 32nd byte.
- R5: A read with `rd_en` high at a clock edge puts the addressed byte on `rd_data` after that edge. Successive reads return the block's bytes in the order they were written.
- R6: Reads beyond `blk_cnt` return the older contents of those bank locations, left from the previous block stored in the same bank.
- R7: After the 32nd read of a block, the read position wraps to the block's first byte (modulo 32).
- R8: Over-reading one block does not change the bytes of the next block, which has already been stored in another bank.
- R9: A release pulse while `blk_rdy` is 1 frees the block. After that edge, the outputs show the next bank's count and ready flag, and the next read returns that bank's first byte.
- R10: A release pulse while `blk_rdy` is 0 is ignored. The host stays on the same bank, and the next block stored there is reported and read normally.
- R11: A byte written while every bank holds an unreleased block is dropped. It forms no block and alters no stored data.
- R12: While `rd_en` is low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Received byte present on `wr_data` |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | Marks the final byte of a block |
| rd_en | input | 1 | Host read strobe, one byte per cycle |
| rd_addr | input | 5 | Window address; all values alias to the read position |
| rd_release | input | 1 | Host releases the pending block |
| rd_data | output | 8 | Byte returned by the last read |
| blk_cnt | output | 5 | Bytes in the pending block, 0 meaning 32 when ready |
| blk_rdy | output | 1 | A closed block is pending for the host |

## Verification
The ready flag and the count change at the edge that stores a block's final byte or accepts a release. Read data is registered, so it appears after the edge that samples `rd_en`. Each of these results is therefore due one edge after its stimulus. The bench changes its inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge, so every check looks at the cycle in which its result first becomes visible. The over-read, wrap and stale-data cases are arranged so that both banks hold known bytes before any read crosses the count.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    // Default width of one received byte lane.
    localparam int RXW_DW = 8;

    // One write-side beat: the byte and its end-of-block marker.
    typedef struct packed {
        logic              last;
        logic [RXW_DW-1:0] data;
    } rxw_beat_t;

    // Per-bank occupancy as seen by the writer.
    typedef enum logic {
        BANK_OPEN  = 1'b0,
        BANK_HELD  = 1'b1
    } rxw_bank_e;

endpackage

// File: rtl/rxw_bank.sv
module rxw_bank #(
    parameter int DW    = 8,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxw_fill.sv
module rxw_fill
    import rxw_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NBANK = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_valid,
    input  rxw_beat_t                      beat,
    input  logic                           rel_go,
    input  logic [((NBANK>1)?$clog2(NBANK):1)-1:0] rel_bank,
    output logic                           wr_fire,
    output logic [((NBANK>1)?$clog2(NBANK):1)-1:0] wbank,
    output logic [$clog2(DEPTH)-1:0]       waddr,
    output logic [NBANK-1:0]               held,
    output logic [NBANK-1:0][$clog2(DEPTH):0] len
);

    localparam int AW = $clog2(DEPTH);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int LW = AW + 1;

    rxw_bank_e             state_q [NBANK];
    logic [NBANK-1:0][LW-1:0] len_q;
    logic [BW-1:0]         wbank_q;
    logic [AW-1:0]         wcnt_q;
    logic                  blk_end;
    logic [BW-1:0]         wbank_nxt;

    assign wr_fire   = wr_valid && (state_q[wbank_q] == BANK_OPEN);
    assign blk_end   = wr_fire && (beat.last || (wcnt_q == AW'(DEPTH-1)));
    assign wbank_nxt = (wbank_q == BW'(NBANK-1)) ? '0 : wbank_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                state_q[b] <= BANK_OPEN;
            end
            len_q   <= '0;
            wbank_q <= '0;
            wcnt_q  <= '0;
        end else begin
            // Release and close always address different banks:
            // a released bank is held, the writer's bank is open.
            if (rel_go) begin
                state_q[rel_bank] <= BANK_OPEN;
            end
            if (wr_fire) begin
                if (blk_end) begin
                    state_q[wbank_q] <= BANK_HELD;
                    len_q[wbank_q]   <= {1'b0, wcnt_q} + LW'(1);
                    wbank_q          <= wbank_nxt;
                    wcnt_q           <= '0;
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_held
            assign held[g] = (state_q[g] == BANK_HELD);
        end
    endgenerate

    assign wbank = wbank_q;
    assign waddr = wcnt_q;
    assign len   = len_q;

endmodule

// File: rtl/rxw_host.sv
module rxw_host #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int NBANK = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rd_en,
    input  logic                              rel_req,
    input  logic [NBANK-1:0]                  held,
    input  logic [NBANK-1:0][$clog2(DEPTH):0] len,
    input  logic [NBANK-1:0][DW-1:0]          bank_rdata,
    output logic                              rel_go,
    output logic [((NBANK>1)?$clog2(NBANK):1)-1:0] hbank,
    output logic [$clog2(DEPTH)-1:0]          rd_off,
    output logic [DW-1:0]                     rd_data,
    output logic [$clog2(DEPTH)-1:0]          blk_cnt,
    output logic                              blk_rdy
);

    localparam int AW = $clog2(DEPTH);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [BW-1:0] hbank_q;
    logic [AW-1:0] off_q;
    logic [DW-1:0] data_q;
    logic          cur_held;
    logic [BW-1:0] hbank_nxt;

    assign cur_held  = held[hbank_q];
    assign rel_go    = rel_req && cur_held;
    assign hbank_nxt = (hbank_q == BW'(NBANK-1)) ? '0 : hbank_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hbank_q <= '0;
            off_q   <= '0;
            data_q  <= '0;
        end else begin
            if (rd_en) begin
                data_q <= bank_rdata[hbank_q];
                // Pool depth is a power of two: the offset wraps on overflow.
                off_q  <= off_q + 1'b1;
            end
            if (rel_go) begin
                hbank_q <= hbank_nxt;
                off_q   <= '0;
            end
        end
    end

    // A full pool reports zero in the count field; the ready flag tells it apart.
    assign blk_cnt = cur_held ? len[hbank_q][AW-1:0] : '0;
    assign blk_rdy = cur_held;
    assign hbank   = hbank_q;
    assign rd_off  = off_q;
    assign rd_data = data_q;

endmodule

// File: rtl/rxw_window.sv
module rxw_window
    import rxw_pkg::*;
#(
    parameter int DW    = RXW_DW,
    parameter int DEPTH = 32,
    parameter int NBANK = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr_last,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    input  logic                     rd_release,
    output logic [DW-1:0]            rd_data,
    output logic [$clog2(DEPTH)-1:0] blk_cnt,
    output logic                     blk_rdy
);

    localparam int AW = $clog2(DEPTH);
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int LW = AW + 1;

    rxw_beat_t                beat;
    logic                     wr_fire;
    logic [BW-1:0]            wbank;
    logic [AW-1:0]            waddr;
    logic [NBANK-1:0]         held;
    logic [NBANK-1:0][LW-1:0] len;
    logic                     rel_go;
    logic [BW-1:0]            hbank;
    logic [AW-1:0]            rd_off;
    logic [NBANK-1:0][DW-1:0] bank_rdata;
    logic                     unused_addr;

    // Every window address aliases to the current read position.
    assign unused_addr = ^rd_addr;

    assign beat.last = wr_last;
    assign beat.data = RXW_DW'(wr_data);

    rxw_fill #(
        .DEPTH (DEPTH),
        .NBANK (NBANK)
    ) u_fill (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .beat     (beat),
        .rel_go   (rel_go),
        .rel_bank (hbank),
        .wr_fire  (wr_fire),
        .wbank    (wbank),
        .waddr    (waddr),
        .held     (held),
        .len      (len)
    );

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            rxw_bank #(
                .DW    (DW),
                .DEPTH (DEPTH)
            ) u_bank (
                .clk   (clk),
                .we    (wr_fire && (wbank == BW'(g))),
                .waddr (waddr),
                .wdata (wr_data),
                .raddr (rd_off),
                .rdata (bank_rdata[g])
            );
        end
    endgenerate

    rxw_host #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .NBANK (NBANK)
    ) u_host (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rel_req    (rd_release),
        .held       (held),
        .len        (len),
        .bank_rdata (bank_rdata),
        .rel_go     (rel_go),
        .hbank      (hbank),
        .rd_off     (rd_off),
        .rd_data    (rd_data),
        .blk_cnt    (blk_cnt),
        .blk_rdy    (blk_rdy)
    );

endmodule

// File: rtl/rxw_window_chk.sv
module rxw_window_chk #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          rd_en,
    input logic          rd_release,
    input logic [DW-1:0] rd_data,
    input logic [AW-1:0] blk_cnt,
    input logic          blk_rdy
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (blk_cnt == '0 && !blk_rdy && rd_data == '0)); // R1

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (blk_rdy && !rd_release) |=> (blk_rdy && $stable(blk_cnt))); // R3

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rd_release && !blk_rdy && !wr_valid) |=> !blk_rdy); // R10

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R12

endmodule

bind rxw_window rxw_window_chk #(
    .DW (DW),
    .AW (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .rd_en      (rd_en),
    .rd_release (rd_release),
    .rd_data    (rd_data),
    .blk_cnt    (blk_cnt),
    .blk_rdy    (blk_rdy)
);

// File: tb/rxw_window_tb.sv
`timescale 1ns/1ps
module rxw_window_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = '0;
    logic       rd_release = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] blk_cnt;
    logic       blk_rdy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rxw_window u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_release (rd_release),
        .rd_data    (rd_data),
        .blk_cnt    (blk_cnt),
        .blk_rdy    (blk_rdy)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(int n, logic [7:0] base, bit mark_end);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = base + 8'(i);
            wr_last  = mark_end && (i == n - 1);
            step();
        end
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic read_one(string req, logic [4:0] addr, logic [7:0] exp);
        rd_en   = 1'b1;
        rd_addr = addr;
        step();
        rd_en   = 1'b0;
        check(req, int'(rd_data), int'(exp));
    endtask

    task automatic release_blk();
        rd_release = 1'b1;
        step();
        rd_release = 1'b0;
    endtask

    task automatic t_reset();
        step();
        step();
        rst = 1'b0;
        check("R1 cnt", int'(blk_cnt), 0);
        check("R1 rdy", int'(blk_rdy), 0);
        check("R1 data", int'(rd_data), 0);
    endtask

    task automatic t_alias_read();
        logic [4:0] addrs [5] = '{5'd0, 5'd31, 5'd7, 5'd16, 5'd1};
        push(5, 8'h10, 1'b1);
        check("R3 rdy", int'(blk_rdy), 1);
        check("R3 cnt", int'(blk_cnt), 5);
        for (int i = 0; i < 5; i++) begin
            read_one("R2/R5 aliased read", addrs[i], 8'h10 + 8'(i));
        end
        step();
        check("R12 hold", int'(rd_data), 8'h14);
        release_blk();
        check("R9 empty after release", int'(blk_rdy), 0);
    endtask

    task automatic t_full_overread();
        push(32, 8'h40, 1'b0);
        check("R4 closes at 32", int'(blk_rdy), 1);
        check("R3 full count", int'(blk_cnt), 0);
        push(3, 8'hA0, 1'b1);
        push(1, 8'hEE, 1'b1);
        check("R3 count held", int'(blk_cnt), 0);
        for (int i = 0; i < 34; i++) begin
            read_one("R7 wrap read", 5'((i * 5) % 32), 8'h40 + 8'(i % 32));
        end
        release_blk();
        check("R9 next rdy", int'(blk_rdy), 1);
        check("R9 next cnt", int'(blk_cnt), 3);
        read_one("R8 next block", 5'd9, 8'hA0);
        read_one("R8 next block", 5'd3, 8'hA1);
        read_one("R8 next block", 5'd30, 8'hA2);
        read_one("R6 stale", 5'd0, 8'h13);
        read_one("R6 stale", 5'd0, 8'h14);
        release_blk();
        check("R11 dropped byte", int'(blk_rdy), 0);
    endtask

    task automatic t_idle_release();
        release_blk();
        check("R10 ignored rdy", int'(blk_rdy), 0);
        push(2, 8'h77, 1'b1);
        check("R10 rdy", int'(blk_rdy), 1);
        check("R10 cnt", int'(blk_cnt), 2);
        read_one("R10 read", 5'd12, 8'h77);
        read_one("R10 read", 5'd4, 8'h78);
    endtask

    initial begin
        t_reset();
        t_alias_read();
        t_full_overread();
        t_idle_release();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule